// File: doc/BRIEF.md
# Packed Saturating SIMD Adder

This block is a 64-bit packed integer arithmetic unit. Each input pair of 64-bit operands is split into independent lanes of 8, 16 or 32 bits. Every lane is added or subtracted on its own, and no carry crosses a lane boundary. Each lane's result either wraps, clamps to the signed range, or clamps to the unsigned range. The unit also forms bitwise AND, OR and XOR across the whole 64 bits.

A request is presented with `in_valid` high. The registered result appears on the next clock together with `out_valid`. A two-state output machine tracks whether the current output is fresh:
- `ST_IDLE` means that no request was taken on the last edge.
- `ST_EMIT` means that the result register was just loaded.

The transition `ST_IDLE -> ST_EMIT` and the transition `ST_EMIT -> ST_EMIT` are taken on any edge where `in_valid` is high. The transitions `ST_EMIT -> ST_IDLE` and `ST_IDLE -> ST_IDLE` are taken when `in_valid` is low.

Unsigned saturating subtraction clamps at zero. Software can therefore form a per-lane absolute difference by issuing a-b and b-a, then ORing the two results.

Top module: `simd_lane_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` is high on the cycle after an edge where `in_valid` was high, and low otherwise. `result` loads only on an edge where `in_valid` is high, and holds its value on every other edge.
- R3: `esize` selects the lane width: 2'b00 gives eight 8-bit lanes, 2'b01 gives four 16-bit lanes, 2'b10 gives two 32-bit lanes, and 2'b11 behaves as 2'b01. Lane k occupies bits [k*W +: W], and no carry or borrow passes between lanes.
- R4: When `amode` is 2'b00 (wrap), each lane keeps the low W bits of its sum or difference. `amode` 2'b11 behaves as 2'b00.
- R5: When `amode` is 2'b01 (signed saturation), a lane result above the signed maximum becomes the maximum, and one below the signed minimum becomes the minimum. For 16-bit lanes these are 0x7FFF and 0x8000.
- R6: When `amode` is 2'b10 (unsigned saturation), an add that overflows a lane gives all ones in that lane.
- R7: When `amode` is 2'b10, a subtract whose lane result would be negative gives zero in that lane. ORing (a-b) and (b-a) under this mode gives |a-b| per lane.
- R8: `op` encodes the operation: 3'b000 add, 3'b001 subtract (a-b), 3'b010 AND, 3'b011 OR, 3'b100 XOR. The codes 3'b101 to 3'b111 act as add. The three bitwise operations act on all 64 bits and ignore `esize` and `amode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation code |
| esize | input | 2 | Lane width select |
| amode | input | 2 | Arithmetic mode select |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result register was loaded on the last edge |
| result | output | 64 | Registered packed result |

## Verification
Within one operation, some lanes can clamp upward while others clamp downward or pass through unclamped. These cases all fall on the same edge. The bench provokes them with operands that mix positive and negative extremes lane by lane, at each lane width. A behavioural integer model judges every lane separately against the register's contents on the next cycle.

The other coincidence is a new request arriving on the cycle after a held output. Back-to-back and gapped valid patterns test it, with `out_valid` and the held value compared on every clock.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [1:0] {
        ES_B8  = 2'b00,
        ES_W16 = 2'b01,
        ES_D32 = 2'b10,
        ES_ALT = 2'b11
    } esize_e;

    typedef enum logic [1:0] {
        AM_WRAP = 2'b00,
        AM_SSAT = 2'b01,
        AM_USAT = 2'b10,
        AM_RSVD = 2'b11
    } amode_e;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100,
        OP_X5  = 3'b101,
        OP_X6  = 3'b110,
        OP_X7  = 3'b111
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } st_e;

endpackage

// File: rtl/simd_sat_lane.sv
module simd_sat_lane #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic              sub,
    input  logic [1:0]        amode,
    output logic [LANE_W-1:0] y
);
    import simd_pkg::*;

    localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};

    logic [LANE_W:0] uext;
    logic [LANE_W:0] sext;
    logic            s_ovf;

    // One guard bit per lane: carry/borrow for unsigned, sign for signed.
    always_comb begin
        if (sub) begin
            uext = {1'b0, a} - {1'b0, b};
            sext = {a[LANE_W-1], a} - {b[LANE_W-1], b};
        end else begin
            uext = {1'b0, a} + {1'b0, b};
            sext = {a[LANE_W-1], a} + {b[LANE_W-1], b};
        end
        s_ovf = sext[LANE_W] ^ sext[LANE_W-1];
    end

    always_comb begin
        case (amode_e'(amode))
            AM_SSAT: begin
                if (s_ovf) y = sext[LANE_W] ? SMIN : SMAX;
                else       y = sext[LANE_W-1:0];
            end
            AM_USAT: begin
                if (uext[LANE_W]) y = sub ? '0 : '1;
                else              y = uext[LANE_W-1:0];
            end
            default: y = uext[LANE_W-1:0];
        endcase
    end

endmodule

// File: rtl/simd_arith_grid.sv
module simd_arith_grid #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic [1:0]        amode,
    output logic [DATA_W-1:0] y
);
    localparam int N_LANES = DATA_W / LANE_W;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        simd_sat_lane #(.LANE_W(LANE_W)) u_lane (
            .a     (a[i*LANE_W +: LANE_W]),
            .b     (b[i*LANE_W +: LANE_W]),
            .sub   (sub),
            .amode (amode),
            .y     (y[i*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/simd_bitwise.sv
module simd_bitwise #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [2:0]        op,
    output logic [DATA_W-1:0] y,
    output logic              is_logic
);
    import simd_pkg::*;

    always_comb begin
        is_logic = 1'b1;
        case (op_e'(op))
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: begin
                y        = '0;
                is_logic = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
    parameter int DATA_W      = 64,
    parameter int BASE_LANE_W = 8,
    parameter int NUM_SIZES   = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [2:0]  op,
    input  logic [1:0]  esize,
    input  logic [1:0]  amode,
    input  logic [63:0] src_a,
    input  logic [63:0] src_b,
    output logic        out_valid,
    output logic [63:0] result
);
    import simd_pkg::*;

    logic [DATA_W-1:0] grid_res [NUM_SIZES];
    logic [DATA_W-1:0] arith_sel;
    logic [DATA_W-1:0] bit_res;
    logic [DATA_W-1:0] next_res;
    logic [DATA_W-1:0] result_q;
    logic              is_logic;
    logic              is_sub;
    st_e               state_q;
    st_e               state_d;

    assign is_sub = (op_e'(op) == OP_SUB);

    // One lane grid per supported width, all evaluated in parallel.
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        simd_arith_grid #(
            .DATA_W (DATA_W),
            .LANE_W (BASE_LANE_W << g)
        ) u_grid (
            .a     (src_a),
            .b     (src_b),
            .sub   (is_sub),
            .amode (amode),
            .y     (grid_res[g])
        );
    end

    simd_bitwise #(.DATA_W(DATA_W)) u_bitwise (
        .a        (src_a),
        .b        (src_b),
        .op       (op),
        .y        (bit_res),
        .is_logic (is_logic)
    );

    always_comb begin
        case (esize_e'(esize))
            ES_B8:   arith_sel = grid_res[0];
            ES_D32:  arith_sel = grid_res[2];
            default: arith_sel = grid_res[1];
        endcase
        next_res = is_logic ? bit_res : arith_sel;
    end

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        result_q <= '0;
        else if (in_valid) result_q <= next_res;
    end

    assign out_valid = (state_q == ST_EMIT);
    assign result    = result_q;

endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [2:0]  op,
    input logic [1:0]  amode,
    input logic [63:0] src_a,
    input logic [63:0] src_b,
    input logic        out_valid,
    input logic [63:0] result
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == 64'd0));

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    assert_usat_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'b000 && amode == 2'b10 && src_a == '1) |=> result == '1);

    assert_usat_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'b001 && amode == 2'b10 && src_a == '0) |=> result == '0);

    assert_and_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'b010) |=> result == $past(src_a & src_b));

    assert_xor_self_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'b100 && src_a == src_b) |=> result == '0);

endmodule

bind simd_lane_alu simd_lane_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .amode     (amode),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/simd_lane_alu_tb.sv
`timescale 1ns/1ps
module simd_lane_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [1:0]  esize = 2'd0;
    logic [1:0]  amode = 2'd0;
    logic [63:0] src_a = 64'd0;
    logic [63:0] src_b = 64'd0;
    logic        out_valid;
    logic [63:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    logic [63:0] exp_res = 64'd0;
    logic        exp_v   = 1'b0;

    always #10 clk = ~clk;

    simd_lane_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .esize(esize), .amode(amode), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(logic [2:0] o, logic [1:0] e, logic [1:0] m,
                                          logic [63:0] x, logic [63:0] y);
        logic [63:0] acc;
        int w;
        longint mask, smax, smin, ua, ub, r;
        if (o == 3'b010) return x & y;
        if (o == 3'b011) return x | y;
        if (o == 3'b100) return x ^ y;
        w = (e == 2'b00) ? 8 : (e == 2'b10) ? 32 : 16;
        mask = (longint'(1) << w) - 1;
        smax = (longint'(1) << (w - 1)) - 1;
        smin = -(longint'(1) << (w - 1));
        acc = '0;
        for (int i = 0; i < 64 / w; i++) begin
            ua = longint'(x >> (i * w)) & mask;
            ub = longint'(y >> (i * w)) & mask;
            if (m == 2'b01) begin
                if (ua > smax) ua = ua - (mask + 1);
                if (ub > smax) ub = ub - (mask + 1);
            end
            r = (o == 3'b001) ? ua - ub : ua + ub;
            if (m == 2'b01) begin
                if (r > smax) r = smax;
                if (r < smin) r = smin;
            end else if (m == 2'b10) begin
                if (r > mask) r = mask;
                if (r < 0)    r = 0;
            end
            acc = acc | (64'(r & mask) << (i * w));
        end
        return acc;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(string tag, logic v, logic [2:0] o, logic [1:0] e,
                         logic [1:0] m, logic [63:0] x, logic [63:0] y);
        in_valid = v; op = o; esize = e; amode = m; src_a = x; src_b = y;
        if (v) exp_res = model(o, e, m, x, y);
        exp_v = v;
        @(negedge clk);
        chk({tag, " result"}, result, exp_res);
        chk({tag, " valid"}, {63'd0, out_valid}, {63'd0, exp_v});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R2 actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [63:0] d1, d2, dabs, pa, pb;
        repeat (3) @(negedge clk);
        chk("R1 reset result", result, 64'd0);
        chk("R1 reset valid", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R4: wrap at each width, carries stay in their lane
        apply("R4 wrap b8", 1, 3'b000, 2'b00, 2'b00, 64'hFF01_80FF_7F00_FFFF, 64'h0101_80FF_0100_0101);
        apply("R3 wrap w16", 1, 3'b000, 2'b01, 2'b00, 64'hFFFF_0001_8000_7FFF, 64'h0001_FFFF_8000_0001);
        apply("R3 wrap d32", 1, 3'b001, 2'b10, 2'b00, 64'h0000_0000_0000_0005, 64'h0000_0001_0000_0006);
        apply("R3 esize 11", 1, 3'b000, 2'b11, 2'b00, 64'hFFFF_0001_8000_7FFF, 64'h0001_FFFF_8000_0001);
        apply("R4 amode 11", 1, 3'b001, 2'b00, 2'b11, 64'h0010_2030_4050_6070, 64'h7060_5040_3020_1000);

        // R5 signed saturation, mixed directions in one operation
        apply("R5 ssat w16", 1, 3'b000, 2'b01, 2'b01, 64'h7FFF_8000_1234_7000, 64'h0001_FFFF_0001_1000);
        apply("R5 ssat b8 sub", 1, 3'b001, 2'b00, 2'b01, 64'h7F80_0080_7F00_1020, 64'hFF01_0101_8001_2010);
        apply("R5 ssat d32", 1, 3'b000, 2'b10, 2'b01, 64'h7FFF_FFFF_8000_0000, 64'h0000_0010_8000_0000);

        // R6 unsigned saturating add
        apply("R6 usat b8", 1, 3'b000, 2'b00, 2'b10, 64'hFF80_0102_F00F_8001, 64'h0180_0102_2010_7F00);
        apply("R6 usat all ones", 1, 3'b000, 2'b10, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0000);

        // R7 unsigned saturating subtract and absolute difference
        apply("R7 usat sub w16", 1, 3'b001, 2'b01, 2'b10, 64'h0001_FFFF_0000_8000, 64'h0002_0001_0001_8000);
        pa = 64'h10F0_3355_00FF_7F81;
        pb = 64'h2001_3366_FF00_817F;
        apply("R7 absdiff ab", 1, 3'b001, 2'b00, 2'b10, pa, pb);
        d1 = result;
        apply("R7 absdiff ba", 1, 3'b001, 2'b00, 2'b10, pb, pa);
        d2 = result;
        dabs = '0;
        for (int i = 0; i < 8; i++) begin
            int xa, xb;
            xa = int'(pa[i*8 +: 8]);
            xb = int'(pb[i*8 +: 8]);
            dabs[i*8 +: 8] = 8'((xa > xb) ? xa - xb : xb - xa);
        end
        chk("R7 absdiff or", d1 | d2, dabs);

        // R8 bitwise and reserved codes
        apply("R8 and", 1, 3'b010, 2'b00, 2'b01, 64'hF0F0_1234_FFFF_0000, 64'hFF00_00FF_1234_FFFF);
        apply("R8 or", 1, 3'b011, 2'b10, 2'b10, 64'hF0F0_1234_FFFF_0000, 64'h0F00_00FF_1234_0001);
        apply("R8 xor", 1, 3'b100, 2'b01, 2'b01, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_0000_FFFF_0000);
        apply("R8 code 101", 1, 3'b101, 2'b00, 2'b10, 64'hFF10_0000_0000_0001, 64'h0110_0000_0000_0001);
        apply("R8 code 111", 1, 3'b111, 2'b01, 2'b00, 64'h0000_0000_FFFF_0001, 64'h0000_0000_0001_0001);

        // R2 hold while idle, then gapped and back-to-back requests
        apply("R2 idle hold", 0, 3'b000, 2'b00, 2'b00, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
        apply("R2 idle hold2", 0, 3'b011, 2'b10, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        apply("R2 resume", 1, 3'b000, 2'b00, 2'b00, 64'h0102_0304_0506_0708, 64'h0101_0101_0101_0101);

        for (int k = 0; k < 400; k++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (k % 5 == 0) rb = ~ra;
            apply("R3 random", ($urandom % 4) != 0, 3'($urandom), 2'($urandom),
                  2'($urandom), ra, rb);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule